// File: doc/BRIEF.md
# USB Controller Interrupt Aggregator

This block sits between a USB on-the-go controller core and a host processor and merges the core's interrupt requests into one level interrupt line. Endpoint requests go into one 32-bit pending word: transmit endpoints fill the low half and receive endpoints fill the high half. Core-level USB events go into a second pending word in a 9-bit field. Each pending word has its own enable mask. Software changes pending bits and mask bits through write-one set and clear aliases, so it never needs a read-modify-write. It can also read a masked view of each word.

The interrupt line stays high after it asserts, until software writes the end-of-interrupt register. A handler therefore acknowledges each interrupt explicitly, and any request still pending after that write raises the line again. The block also provides a fixed identification value, a control register with a self-clearing soft reset, and a status register that shows the synchronized level of the bus-power drive signal.

Top module: `usb_irq_wrap`

## Requirements
- R1: After reset, both pending words and both masks are zero and `irq` is low.
- R2: A pulse on `ep_tx_evt[i]` sets endpoint pending bit i, and a pulse on `ep_rx_evt[j]` sets bit 16+j. Bit 16 (receive endpoint 0) and any bit outside these fields can never be set, by hardware or by software, and always reads 0.
- R3: A pulse on `core_evt[k]` sets core pending bit 16+k. The bus-power drive event is `core_evt[8]`, which appears at bit 24. Core bits 0–15 and 25–31 always read 0.
- R4: A write to a set alias (group base +0x04) ORs the written ones into the pending word. A write to a clear alias (+0x08) clears the written ones. If a hardware event and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: Writes to mask-set (+0x10) and mask-clear (+0x14) set and clear mask bits. The mask reads at +0x0C. Only valid bits of the group can be set.
- R6: The masked view (+0x18) reads the pending word ANDed with its mask. The pending word reads at +0x00. The endpoint group base is 0x20 and the core group base is 0x40.
- R7: `irq` rises one cycle after a nonzero masked view appears in either group. Once high, it stays high until an end-of-interrupt write, even if the pending bits are cleared first.
- R8: A write of any value to 0x60 (end-of-interrupt) while `irq` is high drops `irq` on the next edge. If a masked request is still pending, `irq` rises again one cycle later.
- R9: Writing a 1 to bit 0 of the control register at 0x04 clears both pending words and both masks in the same edge, and this takes priority over events. The control register always reads 0. The soft reset does not lower `irq`.
- R10: Bit 0 of status (0x08) follows `vbus_drv` after a two-flop synchronizer: it is still 0 one cycle after `vbus_drv` changes and shows the new level two cycles after. Status bits 31:1 read 0.
- R11: The identification register at 0x00 always reads the nonzero `REV_ID`. Reserved offsets, unaligned addresses and write-only aliases read 0. Writes to the identification, pending or mask read addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (7) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| ep_tx_evt | input | TX_EP_N (16) | Transmit endpoint request pulses |
| ep_rx_evt | input | RX_EP_N (16) | Receive endpoint request pulses (bit 0 ignored) |
| core_evt | input | CORE_EV_N (9) | Core event pulses; bit 8 is the bus-power drive event |
| vbus_drv | input | 1 | Asynchronous bus-power drive level |
| irq | output | 1 | Level interrupt to the processor |

## Verification
The assertions assume that the event inputs are synchronous one-cycle pulses, that `bus_addr` and the write strobe are stable around the sampling edge, and that only `vbus_drv` is asynchronous. The bench drives every input on the falling edge and holds it for exactly one rising edge. It raises `vbus_drv` only through the status path. All register accesses are made at aligned addresses, except for a deliberate probe of read-only and reserved locations.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;
    localparam int DW     = 32;
    localparam int RX_LSB = 16;

    // word index = byte address [6:2]
    localparam logic [4:0] IDX_REV  = 5'd0;
    localparam logic [4:0] IDX_CTRL = 5'd1;
    localparam logic [4:0] IDX_STAT = 5'd2;
    localparam logic [4:0] IDX_EOI  = 5'd24;

    typedef enum logic [2:0] {
        SLOT_SRC   = 3'd0,
        SLOT_SET   = 3'd1,
        SLOT_CLR   = 3'd2,
        SLOT_MSK   = 3'd3,
        SLOT_MSET  = 3'd4,
        SLOT_MCLR  = 3'd5,
        SLOT_MVIEW = 3'd6
    } grp_slot_e;

    typedef struct packed {
        logic [DW-1:0] src;
        logic [DW-1:0] msk;
    } bank_st_t;
endpackage

// File: rtl/usbirq_bank.sv
module usbirq_bank
    import usbirq_pkg::*;
#(
    parameter logic [DW-1:0] VALID = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clr,
    input  logic [DW-1:0] hw_set,
    input  logic          sw_set_we,
    input  logic          sw_clr_we,
    input  logic          msk_set_we,
    input  logic          msk_clr_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] src_o,
    output logic [DW-1:0] msk_o
);
    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sw_clr_we)  st_d.src = st_d.src & ~wdata;
        if (sw_set_we)  st_d.src = st_d.src | wdata;
        // hardware events are applied after the clear so they win
        st_d.src = (st_d.src | hw_set) & VALID;
        if (msk_clr_we) st_d.msk = st_d.msk & ~wdata;
        if (msk_set_we) st_d.msk = st_d.msk | wdata;
        st_d.msk = st_d.msk & VALID;
        if (soft_clr)   st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src_o = st_q.src;
    assign msk_o = st_q.msk;
endmodule

// File: rtl/usbirq_sync.sv
module usbirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb sh_d = {sh_q[STAGES-2:0], din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/usbirq_eoi_gate.sv
module usbirq_eoi_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic eoi_wr,
    output logic irq_o
);
    logic irq_d, irq_q;

    // held high until acknowledged; re-evaluated the cycle after
    always_comb irq_d = irq_q ? !eoi_wr : pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/usb_irq_wrap.sv
module usb_irq_wrap
    import usbirq_pkg::*;
#(
    parameter int          ADDR_W      = 7,
    parameter int          TX_EP_N     = 16,
    parameter int          RX_EP_N     = 16,
    parameter int          CORE_EV_N   = 9,
    parameter int          CORE_EV_LSB = 16,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] REV_ID      = 32'h0001_0A01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    input  logic [TX_EP_N-1:0]   ep_tx_evt,
    input  logic [RX_EP_N-1:0]   ep_rx_evt,
    input  logic [CORE_EV_N-1:0] core_evt,
    input  logic                 vbus_drv,
    output logic                 irq
);
    localparam logic [DW-1:0] TX_FIELD   = DW'((64'd1 << TX_EP_N) - 64'd1);
    localparam logic [DW-1:0] RX_FIELD   = DW'(((64'd1 << RX_EP_N) - 64'd2) << RX_LSB);
    localparam logic [DW-1:0] EP_VALID   = TX_FIELD | RX_FIELD;
    localparam logic [DW-1:0] CORE_VALID = DW'(((64'd1 << CORE_EV_N) - 64'd1) << CORE_EV_LSB);
    localparam int            NGRP       = 2;

    logic            aligned, wr_hit, soft_clr, eoi_wr, vbus_s, pending;
    logic [4:0]      widx;
    logic [NGRP-1:0][DW-1:0] hw_set, src_w, msk_w;
    logic [DW-1:0]   ep_src_w, ep_msk_w, core_src_w, core_msk_w;

    assign aligned  = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 7) == '0);
    assign widx     = bus_addr[6:2];
    assign wr_hit   = bus_sel && bus_wr && aligned;
    assign soft_clr = wr_hit && (widx == IDX_CTRL) && bus_wdata[0];
    assign eoi_wr   = wr_hit && (widx == IDX_EOI);

    assign hw_set[0] = DW'(ep_tx_evt) | (DW'(ep_rx_evt) << RX_LSB);
    assign hw_set[1] = DW'(core_evt) << CORE_EV_LSB;

    for (genvar g = 0; g < NGRP; g++) begin : g_bank
        localparam logic [DW-1:0] VMASK = (g == 0) ? EP_VALID : CORE_VALID;
        localparam logic [1:0]    GSEL  = 2'(g + 1);
        logic grp_wr;
        assign grp_wr = wr_hit && (widx[4:3] == GSEL);

        usbirq_bank #(.VALID(VMASK)) i_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .soft_clr   (soft_clr),
            .hw_set     (hw_set[g]),
            .sw_set_we  (grp_wr && (widx[2:0] == SLOT_SET)),
            .sw_clr_we  (grp_wr && (widx[2:0] == SLOT_CLR)),
            .msk_set_we (grp_wr && (widx[2:0] == SLOT_MSET)),
            .msk_clr_we (grp_wr && (widx[2:0] == SLOT_MCLR)),
            .wdata      (bus_wdata),
            .src_o      (src_w[g]),
            .msk_o      (msk_w[g])
        );
    end

    assign ep_src_w   = src_w[0];
    assign ep_msk_w   = msk_w[0];
    assign core_src_w = src_w[1];
    assign core_msk_w = msk_w[1];

    assign pending = (|(ep_src_w & ep_msk_w)) || (|(core_src_w & core_msk_w));

    usbirq_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (vbus_drv),
        .dout  (vbus_s)
    );

    usbirq_eoi_gate i_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .eoi_wr  (eoi_wr),
        .irq_o   (irq)
    );

    always_comb begin
        logic [DW-1:0] s, m;
        bus_rdata = '0;
        s = widx[4] ? core_src_w : ep_src_w;
        m = widx[4] ? core_msk_w : ep_msk_w;
        if (aligned) begin
            if (widx == IDX_REV)       bus_rdata = REV_ID;
            else if (widx == IDX_STAT) bus_rdata = DW'(vbus_s);
            else if (widx[4:3] == 2'b01 || widx[4:3] == 2'b10) begin
                case (widx[2:0])
                    SLOT_SRC:   bus_rdata = s;
                    SLOT_MSK:   bus_rdata = m;
                    SLOT_MVIEW: bus_rdata = s & m;
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/usbirq_chk.sv
module usbirq_chk #(
    parameter int          ADDR_W     = 7,
    parameter int          TX_EP_N    = 16,
    parameter logic [31:0] EP_VALID   = 32'hFFFE_FFFF,
    parameter logic [31:0] CORE_VALID = 32'h01FF_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [TX_EP_N-1:0] ep_tx_evt,
    input logic              irq,
    input logic [31:0]       ep_src,
    input logic [31:0]       ep_msk,
    input logic [31:0]       core_src,
    input logic [31:0]       core_msk
);
    logic eoi, srst;
    assign eoi  = bus_sel && bus_wr && (bus_addr == ADDR_W'(7'h60));
    assign srst = bus_sel && bus_wr && (bus_addr == ADDR_W'(7'h04)) && bus_wdata[0];

    // R2
    ep_valid_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ep_src & ~EP_VALID) == 0) && ((ep_msk & ~EP_VALID) == 0));
    // R3
    core_valid_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_src & ~CORE_VALID) == 0) && ((core_msk & ~CORE_VALID) == 0));
    // R4
    hw_event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && ep_tx_evt != 0) |=> ((ep_src[TX_EP_N-1:0] & $past(ep_tx_evt)) == $past(ep_tx_evt)));
    // R7
    irq_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !eoi) |=> irq);
    // R8
    eoi_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && eoi) |=> !irq);
    // R9
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (ep_src == 0 && ep_msk == 0 && core_src == 0 && core_msk == 0));
    // R6
    masked_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(7'h38)) |-> (bus_rdata == (ep_src & ep_msk)));
    // R11
    rev_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(7'h00)) |-> (bus_rdata != 0));
    // R9
    ctrl_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(7'h04)) |-> (bus_rdata == 0));
endmodule

bind usb_irq_wrap usbirq_chk #(
    .ADDR_W     (ADDR_W),
    .TX_EP_N    (TX_EP_N),
    .EP_VALID   (EP_VALID),
    .CORE_VALID (CORE_VALID)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ep_tx_evt (ep_tx_evt),
    .irq       (irq),
    .ep_src    (ep_src_w),
    .ep_msk    (ep_msk_w),
    .core_src  (core_src_w),
    .core_msk  (core_msk_w)
);

// File: tb/test_usb_irq_wrap.sv
`timescale 1ns/1ps
module test_usb_irq_wrap;
    localparam logic [31:0] REV = 32'h0001_0A01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [15:0] ep_tx_evt = '0, ep_rx_evt = '0;
    logic [8:0]  core_evt = '0;
    logic        vbus_drv = 1'b0, irq;
    int          n_chk = 0, n_bad = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    usb_irq_wrap i_usb_irq_wrap (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ep_tx_evt(ep_tx_evt), .ep_rx_evt(ep_rx_evt), .core_evt(core_evt),
        .vbus_drv(vbus_drv), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic rchk(input string req, input logic [6:0] a, input logic [31:0] exp);
        bus_addr = a;
        #0.5;
        chk(req, bus_rdata, exp);
    endtask

    task automatic t_reset;
        rchk("R1 ep src", 7'h20, 0);
        rchk("R1 ep mask", 7'h2C, 0);
        rchk("R1 core src", 7'h40, 0);
        rchk("R1 core mask", 7'h4C, 0);
        chk("R1 irq", 32'(irq), 0);
        rchk("R11 rev", 7'h00, REV);
    endtask

    task automatic t_ep_pack;
        @(negedge clk);
        ep_tx_evt = 16'h8001; ep_rx_evt = 16'h0003;
        @(negedge clk);
        ep_tx_evt = '0; ep_rx_evt = '0;
        rchk("R2 ep packing", 7'h20, 32'h0002_8001);
        wr(7'h24, 32'hFFFF_FFFF);
        rchk("R2 rx ep0 never set", 7'h20, 32'hFFFE_FFFF);
        wr(7'h28, 32'hFFFF_FFFF);
        rchk("R4 clear all", 7'h20, 0);
    endtask

    task automatic t_core;
        @(negedge clk);
        core_evt = 9'h100;
        @(negedge clk);
        core_evt = '0;
        rchk("R3 vbus drive event bit 24", 7'h40, 32'h0100_0000);
        wr(7'h44, 32'hFFFF_FFFF);
        rchk("R3 core field only", 7'h40, 32'h01FF_0000);
        wr(7'h48, 32'hFFFF_FFFF);
        rchk("R3 core cleared", 7'h40, 0);
    endtask

    task automatic t_set_clr;
        wr(7'h24, 32'h0000_00F0);
        wr(7'h28, 32'h0000_0030);
        rchk("R4 set then clear", 7'h20, 32'h0000_00C0);
        @(negedge clk);
        ep_tx_evt = 16'h0040;
        bus_sel = 1; bus_wr = 1; bus_addr = 7'h28; bus_wdata = 32'h0000_0040;
        @(negedge clk);
        ep_tx_evt = '0; bus_sel = 0; bus_wr = 0; bus_wdata = '0;
        rchk("R4 event beats clear", 7'h20, 32'h0000_00C0);
        wr(7'h28, 32'hFFFF_FFFF);
    endtask

    task automatic t_mask;
        wr(7'h30, 32'h0000_000F);
        wr(7'h34, 32'h0000_0005);
        rchk("R5 mask set/clear", 7'h2C, 32'h0000_000A);
        wr(7'h50, 32'hFFFF_FFFF);
        rchk("R5 core mask valid bits", 7'h4C, 32'h01FF_0000);
        wr(7'h54, 32'hFFFF_FFFF);
        rchk("R5 core mask cleared", 7'h4C, 0);
    endtask

    task automatic t_irq;
        wr(7'h24, 32'h0000_0006);
        rchk("R6 masked view", 7'h38, 32'h0000_0002);
        chk("R7 irq not yet", 32'(irq), 0);
        @(negedge clk);
        chk("R7 irq rises", 32'(irq), 1);
        wr(7'h28, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R7 irq held after clear", 32'(irq), 1);
        wr(7'h60, 32'h0);
        chk("R8 eoi drops irq", 32'(irq), 0);
        @(negedge clk);
        chk("R8 stays low, nothing pending", 32'(irq), 0);
    endtask

    task automatic t_rearm;
        wr(7'h24, 32'h0000_0002);
        @(negedge clk);
        chk("R7 irq up", 32'(irq), 1);
        wr(7'h60, 32'h1234);
        chk("R8 low after eoi", 32'(irq), 0);
        @(negedge clk);
        chk("R8 re-raised while pending", 32'(irq), 1);
        wr(7'h28, 32'hFFFF_FFFF);
        wr(7'h60, 32'h0);
        @(negedge clk);
        chk("R8 idle", 32'(irq), 0);
    endtask

    task automatic t_soft;
        wr(7'h24, 32'h0000_00FF);
        wr(7'h44, 32'h0100_0000);
        wr(7'h50, 32'h0001_0000);
        @(negedge clk);
        chk("R9 irq before soft reset", 32'(irq), 1);
        wr(7'h04, 32'h1);
        rchk("R9 ep src", 7'h20, 0);
        rchk("R9 ep mask", 7'h2C, 0);
        rchk("R9 core src", 7'h40, 0);
        rchk("R9 core mask", 7'h4C, 0);
        rchk("R9 ctrl reads 0", 7'h04, 0);
        chk("R9 irq unaffected", 32'(irq), 1);
        wr(7'h60, 32'h0);
        @(negedge clk);
        chk("R9 irq after eoi", 32'(irq), 0);
    endtask

    task automatic t_vbus;
        rchk("R10 status low", 7'h08, 0);
        @(negedge clk);
        vbus_drv = 1;
        @(negedge clk);
        rchk("R10 one stage", 7'h08, 0);
        @(negedge clk);
        rchk("R10 synchronized", 7'h08, 1);
        vbus_drv = 0;
        @(negedge clk);
        @(negedge clk);
        rchk("R10 falls", 7'h08, 0);
    endtask

    task automatic t_ro;
        wr(7'h20, 32'hFFFF_FFFF);
        wr(7'h2C, 32'hFFFF_FFFF);
        wr(7'h00, 32'h0);
        rchk("R11 src read-only", 7'h20, 0);
        rchk("R11 mask read-only", 7'h2C, 0);
        rchk("R11 rev fixed", 7'h00, REV);
        rchk("R11 reserved", 7'h10, 0);
        rchk("R11 alias reads 0", 7'h24, 0);
        wr(7'h24, 32'h1);
        rchk("R11 unaligned reads 0", 7'h21, 0);
        wr(7'h28, 32'h1);
        chk("R11 irq quiet", 32'(irq), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_ep_pack;
        t_core;
        t_set_clr;
        t_mask;
        t_irq;
        t_rearm;
        t_soft;
        t_vbus;
        t_ro;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule